// File: doc/BRIEF.md
# Fuse Shadow Bank with Reload Sweep

This block keeps a bank of 32-bit shadow copies of the words held in a one-time-programmable fuse array and exposes them on a memory-mapped register window. Software reads fuse contents from the shadows rather than from the slow array. A reload sweep copies every fuse word into its shadow. The sweep runs once on its own after reset and again whenever software requests it through a set-alias of the control register. While a sweep runs, a busy flag is high.

Each word has a read-lock and a write-lock input. A read of a read-locked word returns a fixed poison pattern instead of data. A write to a write-locked word, or any shadow write during a sweep, is discarded. Every such violation raises a single sticky error flag. While that flag is set, no new shadow read, shadow write or reload request is honoured, until software clears the flag through a write-one-to-clear alias. The control register also carries a word-address field that a neighbouring programming engine reads. Its width, and therefore the positions of the status bits above it, depends on the configured word count.

Top module: `shadow_bank`

## Requirements
- R1: Shadow word n sits at byte address 0x400 + 16*n for n below NWORDS. The control register is at 0x000, its set-alias at 0x004 and its clear-alias at 0x008. A read (bus_re high, bus_we low) returns its data on bus_rdata from the clock edge that samples it. Any other address reads 0, and a write to it changes nothing.
- R2: After reset the block sweeps all shadows from the fuse array by itself. Busy (control bit AF) reads 1 for NWORDS*FUSE_LAT cycles. Afterwards every shadow reads its fuse word.
- R3: Writing 1 to bit AF+2 through the set-alias, while idle and with no error, starts a sweep. Busy and the reload bit (AF+2) then read 1. fuse_addr steps upward from 0 by one, holding each value for FUSE_LAT cycles while fuse_rd_en is high.
- R4: The reload bit clears itself on the same edge that busy falls. At that point every shadow holds the fuse contents seen during the sweep.
- R5: A shadow write while busy is high sets the error bit (AF+1) and leaves the shadow unchanged.
- R6: A shadow write to a word whose wr_lock bit is 1 sets the error bit and is discarded. A write to an unlocked word while idle and error-free stores the data.
- R7: A read of a word whose rd_lock bit is 1 returns 0xBADABADA and sets the error bit.
- R8: The error bit is sticky. While it is set, shadow reads return 0xBADABADA, shadow writes are discarded and reload requests are ignored. Writing 1 to bit AF+1 through the clear-alias clears it.
- R9: A write to the control register loads its low AF bits as the address field. The set-alias ORs bits into that field and the clear-alias clears them. Writes never set busy or error directly.
- R10: AF is 8 when NWORDS is at most 256 and 9 above that, so busy, error and reload move up by one bit in the larger configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (ignored when bus_we is high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fuse_rd_en | output | 1 | Fuse array read enable, high during a sweep |
| fuse_addr | output | IDX_W | Fuse word being read |
| fuse_rdata | input | 32 | Fuse word, valid by the last cycle fuse_addr is held |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |

## Verification
The bench aims at the sweep window and the sticky error. It first writes a shadow early in a sweep, then clears the error and reads that shadow back before the sweep reaches it. A design that let the write through would return the written data instead of the earlier value. With the error set, it tries an unlocked read, a write and a reload request. A design that kept honouring requests would return real data, change the word, or raise busy. A monitor follows fuse_addr through every sweep, so a skipped, repeated or short-held word shows up. A second instance with more than 256 words checks that the status bits move up and that the last word of a large bank still loads.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam logic [31:0] POISON    = 32'hBADA_BADA;
    localparam logic [31:0] WIN_BASE  = 32'h0000_0400;
    localparam logic [31:0] CTRL_OFS  = 32'h0000_0000;
    localparam logic [31:0] SET_OFS   = 32'h0000_0004;
    localparam logic [31:0] CLR_OFS   = 32'h0000_0008;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CTRL,
        RGN_SET,
        RGN_CLR,
        RGN_SHADOW
    } rgn_e;

    typedef struct packed {
        logic reload;
        logic err;
        logic busy;
    } status_t;

    function automatic int addr_field_w(input int nwords);
        return (nwords > 256) ? 9 : 8;
    endfunction

    function automatic int bus_addr_w(input int nwords);
        return $clog2(1024 + nwords * 16);
    endfunction

    function automatic rgn_e rgn_of(input logic [31:0] a, input logic [31:0] n);
        logic [31:0] off;
        off = a - WIN_BASE;
        if (a == CTRL_OFS)      return RGN_CTRL;
        else if (a == SET_OFS)  return RGN_SET;
        else if (a == CLR_OFS)  return RGN_CLR;
        else if (a >= WIN_BASE && a[3:0] == 4'h0 && (off >> 4) < n)
            return RGN_SHADOW;
        else
            return RGN_NONE;
    endfunction

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return (a - WIN_BASE) >> 4;
    endfunction

endpackage

// File: rtl/shadow_decode.sv
module shadow_decode
    import shadow_pkg::*;
#(
    parameter int NWORDS = 64,
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [IDX_W-1:0]  idx
);
    logic [31:0] a32;
    logic [31:0] w32;

    always_comb begin
        a32 = 32'(addr);
        w32 = word_of(a32);
        rgn = rgn_of(a32, 32'(NWORDS));
        idx = IDX_W'(w32);
    end
endmodule

// File: rtl/shadow_sweep.sv
module shadow_sweep #(
    parameter int NWORDS   = 64,
    parameter int IDX_W    = 6,
    parameter int FUSE_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             fuse_rd_en,
    output logic [IDX_W-1:0] fuse_addr,
    output logic             cap_en,
    output logic             done
);
    localparam int LAT_W = (FUSE_LAT > 1) ? $clog2(FUSE_LAT) : 1;
    localparam logic [LAT_W-1:0] LAST_CNT = LAT_W'(FUSE_LAT - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    logic [LAT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                cnt_q  <= '0;
            end
        end else if (cnt_q == LAST_CNT) begin
            cnt_q <= '0;
            if (idx_q == LAST_IDX) busy_q <= 1'b0;
            else                   idx_q  <= idx_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy       = busy_q;
        fuse_rd_en = busy_q;
        fuse_addr  = idx_q;
        cap_en     = busy_q && (cnt_q == LAST_CNT);
        done       = cap_en && (idx_q == LAST_IDX);
    end
endmodule

// File: rtl/shadow_store.sv
module shadow_store #(
    parameter int NWORDS = 64,
    parameter int IDX_W  = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [31:0]      cap_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (cap_en)
            mem[cap_idx] <= cap_data;
        else if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import shadow_pkg::*;
#(
    parameter int NWORDS   = 64,
    parameter int FUSE_LAT = 4,
    parameter int ADDR_W   = shadow_pkg::bus_addr_w(NWORDS),
    parameter int IDX_W    = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fuse_rd_en,
    output logic [IDX_W-1:0]  fuse_addr,
    input  logic [31:0]       fuse_rdata,
    input  logic [NWORDS-1:0] rd_lock,
    input  logic [NWORDS-1:0] wr_lock
);
    localparam int AF     = addr_field_w(NWORDS);
    localparam int BUSY_B = AF;
    localparam int ERR_B  = AF + 1;
    localparam int REL_B  = AF + 2;

    rgn_e             rgn;
    logic [IDX_W-1:0] idx;
    logic             busy;
    logic             cap_en;
    logic             done;
    logic             start;
    logic             err_q;
    logic             rel_q;
    logic [AF-1:0]    addr_q;
    logic [31:0]      shadow_rd;
    logic [31:0]      ctrl_word;
    logic             rd_act;
    logic             sh_wr;
    logic             sh_wr_ok;
    logic             wr_viol;
    logic             rd_viol;
    logic             err_clr;
    status_t          st;

    shadow_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .rgn  (rgn),
        .idx  (idx)
    );

    shadow_sweep #(.NWORDS(NWORDS), .IDX_W(IDX_W), .FUSE_LAT(FUSE_LAT)) u_sweep (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (busy),
        .fuse_rd_en (fuse_rd_en),
        .fuse_addr  (fuse_addr),
        .cap_en     (cap_en),
        .done       (done)
    );

    shadow_store #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .wr_en    (sh_wr_ok),
        .wr_idx   (idx),
        .wr_data  (bus_wdata),
        .cap_en   (cap_en),
        .cap_idx  (fuse_addr),
        .cap_data (fuse_rdata),
        .rd_idx   (idx),
        .rd_data  (shadow_rd)
    );

    always_comb begin
        rd_act   = bus_re && !bus_we;
        sh_wr    = bus_we && (rgn == RGN_SHADOW);
        sh_wr_ok = sh_wr && !busy && !err_q && !wr_lock[idx];
        wr_viol  = sh_wr && (busy || wr_lock[idx]);
        rd_viol  = rd_act && (rgn == RGN_SHADOW) && rd_lock[idx];
        err_clr  = bus_we && (rgn == RGN_CLR) && bus_wdata[ERR_B];
        start    = bus_we && (rgn == RGN_SET) && bus_wdata[REL_B] && !busy && !err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            rel_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            if (err_clr)                err_q <= 1'b0;
            else if (wr_viol || rd_viol) err_q <= 1'b1;

            if (start)     rel_q <= 1'b1;
            else if (done) rel_q <= 1'b0;

            if (bus_we) begin
                unique case (rgn)
                    RGN_CTRL: addr_q <= bus_wdata[AF-1:0];
                    RGN_SET:  addr_q <= addr_q | bus_wdata[AF-1:0];
                    RGN_CLR:  addr_q <= addr_q & ~bus_wdata[AF-1:0];
                    default:  addr_q <= addr_q;
                endcase
            end
        end
    end

    always_comb begin
        st.busy   = busy;
        st.err    = err_q;
        st.reload = rel_q;
        ctrl_word = '0;
        ctrl_word[AF-1:0] = addr_q;
        ctrl_word[BUSY_B] = st.busy;
        ctrl_word[ERR_B]  = st.err;
        ctrl_word[REL_B]  = st.reload;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_act) begin
            case (rgn)
                RGN_CTRL, RGN_SET, RGN_CLR: bus_rdata <= ctrl_word;
                RGN_SHADOW: bus_rdata <= (rd_lock[idx] || err_q) ? POISON : shadow_rd;
                default:    bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk
    import shadow_pkg::*;
#(
    parameter int NWORDS = 64,
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NWORDS-1:0] rd_lock,
    input logic [NWORDS-1:0] wr_lock,
    input logic              busy,
    input logic              err,
    input logic              rel,
    input logic              fuse_rd_en,
    input logic [IDX_W-1:0]  fuse_addr
);
    localparam int ERR_B = addr_field_w(NWORDS) + 1;

    rgn_e             c_rgn;
    logic [IDX_W-1:0] c_idx;
    logic             c_sh;

    always_comb begin
        c_rgn = rgn_of(32'(bus_addr), 32'(NWORDS));
        c_idx = IDX_W'(word_of(32'(bus_addr)));
        c_sh  = (c_rgn == RGN_SHADOW);
    end

    assert_reload_busy_R3: assert property (@(posedge clk) disable iff (rst)
        rel |-> busy);

    assert_fuse_range_R3: assert property (@(posedge clk) disable iff (rst)
        fuse_rd_en |-> (32'(fuse_addr) < 32'(NWORDS)));

    assert_reload_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !rel);

    assert_busy_write_err_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && c_sh && busy) |=> err);

    assert_locked_write_err_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && c_sh && wr_lock[c_idx]) |=> err);

    assert_locked_read_poison_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_re && !bus_we && c_sh && rd_lock[c_idx]) |=> (bus_rdata == POISON && err));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err && !(bus_we && c_rgn == RGN_CLR && bus_wdata[ERR_B])) |=> err);
endmodule

bind shadow_bank shadow_bank_chk #(.NWORDS(NWORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rd_lock    (rd_lock),
    .wr_lock    (wr_lock),
    .busy       (busy),
    .err        (err_q),
    .rel        (rel_q),
    .fuse_rd_en (fuse_rd_en),
    .fuse_addr  (fuse_addr)
);

// File: tb/tb_shadow_bank.sv
module tb_shadow_bank;
    localparam int N    = 8;
    localparam int LAT  = 3;
    localparam int AW   = 11;
    localparam int IW   = 3;
    localparam int WN   = 300;
    localparam int WAW  = 13;
    localparam int WIW  = 9;
    localparam logic [31:0] POIS = 32'hBADA_BADA;
    localparam int BUSY_B = 8, ERR_B = 9, REL_B = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] bus_addr = '0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic fuse_rd_en;
    logic [IW-1:0] fuse_addr;
    logic [31:0] fuse_rdata;
    logic [N-1:0] rd_lock = '0, wr_lock = '0;
    logic [7:0] salt = 8'h11;

    logic [WAW-1:0] w_addr = '0;
    logic w_re = 1'b0;
    logic [31:0] w_rdata;
    logic w_fen;
    logic [WIW-1:0] w_faddr;
    logic [31:0] w_frdata;

    int checks = 0, fails = 0;
    bit finished = 0;
    int seq_bad = 0;

    function automatic logic [31:0] fv(input int i, input logic [7:0] s);
        return 32'h3C00_0000 ^ {4'h0, s, 20'h0} ^ (32'(i) * 32'h0001_0003);
    endfunction
    function automatic logic [31:0] pat(input int i);
        return 32'hC0DE_0000 | (32'(i) * 32'h0000_0011);
    endfunction

    assign fuse_rdata = fv(int'(fuse_addr), salt);
    assign w_frdata   = fv(int'(w_faddr), 8'h22);

    shadow_bank #(.NWORDS(N), .FUSE_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_rd_en(fuse_rd_en),
        .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata), .rd_lock(rd_lock), .wr_lock(wr_lock)
    );

    shadow_bank #(.NWORDS(WN), .FUSE_LAT(1)) dut_wide (
        .clk(clk), .rst(rst), .bus_addr(w_addr), .bus_we(1'b0), .bus_re(w_re),
        .bus_wdata(32'h0), .bus_rdata(w_rdata), .fuse_rd_en(w_fen),
        .fuse_addr(w_faddr), .fuse_rdata(w_frdata), .rd_lock('0), .wr_lock('0)
    );

    // R3 sequence monitor: each fuse address held LAT cycles, stepping by one
    int hold = 0;
    logic [IW-1:0] last_a = '0;
    bit in_sw = 0;
    always @(posedge clk) begin
        if (rst) begin
            in_sw <= 0; hold <= 0;
        end else if (fuse_rd_en) begin
            if (!in_sw) begin
                if (fuse_addr != '0) seq_bad <= seq_bad + 1;
                hold <= 1; in_sw <= 1; last_a <= fuse_addr;
            end else if (fuse_addr == last_a) begin
                hold <= hold + 1;
            end else begin
                if (hold != LAT || fuse_addr != last_a + 1'b1) seq_bad <= seq_bad + 1;
                hold <= 1; last_a <= fuse_addr;
            end
        end else begin
            if (in_sw && (hold != LAT || last_a != IW'(N-1))) seq_bad <= seq_bad + 1;
            in_sw <= 0;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic w_rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        w_addr = WAW'(a); w_re = 1'b1;
        @(negedge clk);
        w_re = 1'b0;
        d = w_rdata;
    endtask

    function automatic logic [31:0] wa(input int i);
        return 32'h400 + 32'(i) * 32'h10;
    endfunction

    task automatic wait_idle(output int cyc);
        logic [31:0] c;
        cyc = 0;
        c = 32'hFFFF_FFFF;
        while (c[BUSY_B] && cyc < 2000) begin
            rd(32'h0, c);
            cyc += 2;
        end
    endtask

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: auto sweep after reset
        rd(32'h0, v);
        chk(v, 32'h1 << BUSY_B, "R2 busy after reset, no error/reload");
        // R10: wide configuration has busy at bit 9
        w_rd(32'h0, v);
        chk(v, 32'h1 << 9, "R10 wide busy bit position");
        wait_idle(cyc);
        checks++;
        if (cyc + 4 < N*LAT || cyc > N*LAT + 3) begin
            fails++;
            $display("FAIL R2 sweep length actual=%0d expected=%0d", cyc + 4, N*LAT);
        end
        for (int i = 0; i < N; i++) begin
            rd(wa(i), v);
            chk(v, fv(i, 8'h11), "R2 shadow loaded after reset");
        end

        // R1: unmapped addresses
        rd(32'h404, v);           chk(v, 32'h0, "R1 unaligned window address reads 0");
        rd(wa(N), v);             chk(v, 32'h0, "R1 word beyond bank reads 0");
        rd(32'h00C, v);           chk(v, 32'h0, "R1 unused control offset reads 0");
        wr(wa(N), 32'hFFFF_FFFF);
        rd(32'h0, v);             chk(v, 32'h0, "R1 write to unmapped has no effect");

        // R6: unlocked writes store data, all words
        for (int i = 0; i < N; i++) wr(wa(i), pat(i));
        for (int i = 0; i < N; i++) begin
            rd(wa(i), v);
            chk(v, pat(i), "R6 unlocked write stored");
        end
        rd(32'h0, v);             chk(v, 32'h0, "R6 no error after legal writes");

        // R6: write-locked word
        wr_lock[5] = 1'b1;
        wr(wa(5), 32'hDEAD_0005);
        rd(32'h0, v);             chk(v, 32'h1 << ERR_B, "R6 locked write sets error");
        wr(32'h8, 32'h1 << ERR_B);
        wr_lock[5] = 1'b0;
        rd(wa(5), v);             chk(v, pat(5), "R6 locked write discarded");

        // R7: read-locked word
        rd_lock[2] = 1'b1;
        rd(wa(2), v);             chk(v, POIS, "R7 locked read returns poison");
        rd(32'h4, v);             chk(v, 32'h1 << ERR_B, "R7 locked read sets error");
        rd_lock[2] = 1'b0;

        // R8: error blocks read, write, reload
        rd(wa(1), v);             chk(v, POIS, "R8 read blocked while error");
        wr(wa(1), 32'h0BAD_0001);
        wr(32'h4, 32'h1 << REL_B);
        rd(32'h0, v);             chk(v, 32'h1 << ERR_B, "R8 reload ignored while error");
        wr(32'h8, 32'h1 << ERR_B);
        rd(32'h0, v);             chk(v, 32'h0, "R8 clear-alias clears error");
        rd(wa(1), v);             chk(v, pat(1), "R8 write discarded while error");
        rd(wa(2), v);             chk(v, pat(2), "R8 unlocked read after clear");

        // R9: address field
        wr(32'h0, 32'hFFFF_F05A);
        rd(32'h0, v);             chk(v, 32'h5A, "R9 control write loads only address field");
        wr(32'h4, 32'h81);
        rd(32'h0, v);             chk(v, 32'hDB, "R9 set-alias ORs address");
        wr(32'h8, 32'h0F);
        rd(32'h0, v);             chk(v, 32'hD0, "R9 clear-alias clears address bits");

        // R3/R5: reload with a rejected write
        salt = 8'h77;
        wr(32'h4, 32'h1 << REL_B);
        rd(32'h0, v);             chk(v, 32'hD0 | (32'h1 << REL_B) | (32'h1 << BUSY_B), "R3 reload and busy set");
        wr(wa(7), 32'h7777_7777);
        rd(32'h0, v);             chk(v[ERR_B], 1'b1, "R5 write during sweep sets error");
        wr(32'h8, 32'h1 << ERR_B);
        rd(wa(7), v);             chk(v, pat(7), "R5 shadow unchanged by write during sweep");
        wait_idle(cyc);
        rd(32'h0, v);             chk(v, 32'hD0, "R4 reload bit self-cleared with busy");
        for (int i = 0; i < N; i++) begin
            rd(wa(i), v);
            chk(v, fv(i, 8'h77), "R4 shadow holds reloaded fuse word");
        end

        // R3 sequence check across both sweeps
        chk(32'(seq_bad), 32'h0, "R3 fuse address order and hold");

        // R10: wide bank after its sweep
        repeat (320) @(negedge clk);
        w_rd(32'h0, v);           chk(v, 32'h0, "R10 wide idle after sweep");
        w_rd(wa(WN-1), v);        chk(v, fv(WN-1, 8'h22), "R10 wide last word loaded");
        w_rd(wa(256), v);         chk(v, fv(256, 8'h22), "R10 wide word above 8-bit range");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule